// File: doc/BRIEF.md
# Configurable asynchronous serial frame transmitter

This block turns one parallel data word into an asynchronous character frame on a single serial line. While no frame is being sent the line sits at mark (1). A frame is a start bit at space (0), then the data bits, least significant first, then an optional parity bit, then a stop interval at mark. All timing is counted in ticks of an oversample enable that runs at sixteen times the bit rate. Every bit lasts sixteen ticks, and bits inside a frame follow each other with no gap.

The word length, parity mode and stop length are set at run time. They are sampled at the moment a word is accepted. The stop interval can be one, one and a half, or two bit times. Which stop lengths are allowed depends on the word length. A combination that is not allowed is sent with one stop bit, and a sticky error flag is raised. A hold input from an external flow controller stops a new frame from starting. It never cuts short a frame that is already on the line.

Words arrive through a valid/ready handshake. The block takes a word only while it is idle and not held. Its busy flag covers the whole frame, up to the end of the stop interval.

Top module: `sertx_frame`

## Requirements
- R1: Out of reset, and whenever busy is low, tx_line is 1. Each frame begins with a start bit of 0 that lasts 16 ticks.
- R2: The data bits follow the start bit least significant bit first. cfg_len codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits; the unused upper bits of in_data are not sent.
- R3: cfg_par codes: 0 means no parity bit, 1 means even parity, 2 means odd parity, and 3 means no parity bit. The parity bit comes right after the last data bit. With even parity the number of ones across the sent data bits and the parity bit is even; with odd parity it is odd.
- R4: cfg_stop codes 0, 1 and 2 select a stop interval at mark of 16, 24 or 32 ticks. Code 1 is allowed only when cfg_len is 0; code 2 is allowed only when cfg_len is not 0; code 0 is always allowed.
- R5: A word accepted with a stop code that is not allowed, or with cfg_stop code 3, is sent with a 16-tick stop interval. cfg_err goes to 1 in the cycle after that acceptance and stays at 1 until reset. At reset cfg_err is 0.
- R6: Each start, data and parity bit lasts exactly 16 ticks. Frame timing moves forward only in cycles where tick is high, and there are no idle gaps inside a frame.
- R7: in_ready is high exactly when busy is low and hold is low. A word is accepted at a clock edge where in_valid and in_ready are both high. busy and the start bit appear in the next cycle.
- R8: While the block is idle and hold is high, no word is accepted. Raising hold during a frame has no effect on that frame.
- R9: busy stays high through the last tick of the stop interval and falls in the following cycle. A waiting word can then be accepted at once.
- R10: The data, word length, parity mode and stop length are taken at acceptance. Changing them while a frame is being sent does not change that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Oversample enable, 16 per bit period |
| in_valid | input | 1 | A data word is offered |
| in_ready | output | 1 | The block takes the offered word at this edge |
| in_data | input | 8 | Data word; bit 0 is sent first |
| cfg_len | input | 2 | Word length code: 5 + code bits |
| cfg_par | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 none |
| cfg_stop | input | 2 | Stop length: 0 one bit, 1 one and a half bits, 2 two bits, 3 reserved |
| hold | input | 1 | Flow-control hold; stops new frames from starting |
| tx_line | output | 1 | Serial line, mark = 1 |
| busy | output | 1 | A frame, including its stop interval, is in progress |
| cfg_err | output | 1 | Sticky flag for a stop/word-length combination that is not allowed |

## Verification
Results fall due at these points:
- in_ready follows hold and busy within the same cycle.
- busy and the start bit appear one cycle after the accepting edge.
- A bit ends on the sixteenth tick-high edge after it began, and the new line level shows in the next cycle.
- busy falls one cycle after the last tick of the stop interval.
- cfg_err rises one cycle after the accepting edge.

The bench keeps a queue of line segments, each with a level and a tick count. It advances the queue on the same rising edges as the design and compares all outputs at the falling edge, so every result is checked in the cycle it is due. The tick enable is driven every cycle, every third cycle, and in an irregular pattern, so that timing can be checked apart from the clock.

// File: rtl/sertx_pkg.sv
// Package sertx_pkg: shared types for the serial frame transmitter.
// Assumes two-bit codes for the parity and stop selections.
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } tx_state_t;

    typedef enum logic [1:0] {
        PAR_NONE  = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_ODD   = 2'd2,
        PAR_NONE3 = 2'd3
    } par_mode_t;

    typedef enum logic [1:0] {
        STOP_ONE  = 2'd0,
        STOP_HALF = 2'd1,
        STOP_TWO  = 2'd2,
        STOP_RSVD = 2'd3
    } stop_sel_t;

endpackage

// File: rtl/sertx_stop_rule.sv
// Module sertx_stop_rule: turns the stop selection and word length code
// into a stop interval in ticks. It also flags combinations that are not
// allowed, which fall back to one bit time.
// Assumes OSR is even, so that a half bit is a whole number of ticks.
module sertx_stop_rule
    import sertx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int LEN_W = 2,
    parameter int CNT_W = 6
) (
    input  logic [LEN_W-1:0] len_code,
    input  logic [1:0]       stop_code,
    output logic [CNT_W-1:0] stop_ticks,
    output logic             illegal
);

    localparam logic [CNT_W-1:0] TICKS_ONE  = CNT_W'(OSR);
    localparam logic [CNT_W-1:0] TICKS_HALF = CNT_W'(OSR + OSR / 2);
    localparam logic [CNT_W-1:0] TICKS_TWO  = CNT_W'(2 * OSR);

    logic shortest_word;
    assign shortest_word = (len_code == '0);

    // Choose the stop interval and flag a selection that is not allowed.
    always_comb begin
        stop_ticks = TICKS_ONE;
        illegal    = 1'b0;
        case (stop_sel_t'(stop_code))
            STOP_ONE:  stop_ticks = TICKS_ONE;
            STOP_HALF: begin
                if (shortest_word) stop_ticks = TICKS_HALF;
                else               illegal    = 1'b1;
            end
            STOP_TWO: begin
                if (!shortest_word) stop_ticks = TICKS_TWO;
                else                illegal    = 1'b1;
            end
            default:   illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/sertx_parity.sv
// Module sertx_parity: works out the parity bit over the active low bits of
// a data word and reports whether a parity bit is sent at all.
// Assumes the word length is MIN_WORD + len_code and fits in DATA_W.
module sertx_parity
    import sertx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int MIN_WORD = 5,
    parameter int LEN_W    = 2
) (
    input  logic [DATA_W-1:0] data,
    input  logic [LEN_W-1:0]  len_code,
    input  logic [1:0]        mode,
    output logic              par_bit,
    output logic              par_en
);

    logic [DATA_W-1:0] active;

    // Mask each bit that lies beyond the selected word length.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign active[i] = data[i] & (i < (MIN_WORD + int'(len_code)));
    end

    // Even parity is the XOR of the active bits; odd parity is its inverse.
    always_comb begin
        par_en  = (par_mode_t'(mode) == PAR_EVEN) || (par_mode_t'(mode) == PAR_ODD);
        par_bit = (^active) ^ (par_mode_t'(mode) == PAR_ODD);
    end

endmodule

// File: rtl/sertx_tick_timer.sv
// Module sertx_tick_timer: counts oversample ticks inside one frame segment
// and signals on the tick that ends the segment.
// Assumes limit is at least 1 and stays constant during a segment.
module sertx_tick_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             at_end
);

    logic [CNT_W-1:0] cnt;

    assign at_end = run && tick && (cnt == limit - CNT_W'(1));

    // Count ticks while running; start again from zero at each segment end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= at_end ? '0 : cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/sertx_seq.sv
// Module sertx_seq: the frame sequencer. It stores the format settings and
// the data word at load time. It then steps through start, data, parity and
// stop, and drives the line from a register.
// Assumes load is pulsed only while busy is low.
module sertx_seq
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16,
    parameter int IDX_W  = 3,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic [IDX_W-1:0]  load_last,
    input  logic              load_par_en,
    input  logic              load_par_bit,
    input  logic [CNT_W-1:0]  load_stop,
    output logic              tx_line,
    output logic              busy
);

    tx_state_t         state;
    logic [DATA_W-1:0] shreg;
    logic [IDX_W-1:0]  bit_idx;
    logic [IDX_W-1:0]  last_idx;
    logic              par_en_q;
    logic              par_q;
    logic [CNT_W-1:0]  stop_q;
    logic              line_q;
    logic              seg_end;
    logic [CNT_W-1:0]  seg_limit;

    assign busy    = (state != ST_IDLE);
    assign tx_line = line_q;

    // Segment length: the selected stop interval, otherwise one bit time.
    always_comb begin
        seg_limit = (state == ST_STOP) ? stop_q : CNT_W'(OSR);
    end

    sertx_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy),
        .tick   (tick),
        .limit  (seg_limit),
        .at_end (seg_end)
    );

    // Step through the frame segments and drive the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            bit_idx  <= '0;
            last_idx <= '0;
            par_en_q <= 1'b0;
            par_q    <= 1'b0;
            stop_q   <= CNT_W'(OSR);
            line_q   <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    line_q <= 1'b1;
                    if (load) begin
                        state    <= ST_START;
                        shreg    <= load_data;
                        last_idx <= load_last;
                        par_en_q <= load_par_en;
                        par_q    <= load_par_bit;
                        stop_q   <= load_stop;
                        bit_idx  <= '0;
                        line_q   <= 1'b0;
                    end
                end
                ST_START: begin
                    if (seg_end) begin
                        state  <= ST_DATA;
                        line_q <= shreg[0];
                    end
                end
                ST_DATA: begin
                    if (seg_end) begin
                        if (bit_idx == last_idx) begin
                            if (par_en_q) begin
                                state  <= ST_PAR;
                                line_q <= par_q;
                            end else begin
                                state  <= ST_STOP;
                                line_q <= 1'b1;
                            end
                        end else begin
                            bit_idx <= bit_idx + IDX_W'(1);
                            shreg   <= shreg >> 1;
                            line_q  <= shreg[1];
                        end
                    end
                end
                ST_PAR: begin
                    if (seg_end) begin
                        state  <= ST_STOP;
                        line_q <= 1'b1;
                    end
                end
                ST_STOP: begin
                    if (seg_end) begin
                        state  <= ST_IDLE;
                        line_q <= 1'b1;
                    end
                end
                default: begin
                    state  <= ST_IDLE;
                    line_q <= 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/sertx_frame.sv
// Module sertx_frame: top level of the configurable asynchronous frame
// transmitter. It gates word acceptance with busy and hold, works out the
// parity and stop settings at acceptance, and keeps the sticky config-error
// flag.
// Assumes tick is one-cycle enable pulses at OSR times the bit rate.
module sertx_frame
    import sertx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int MIN_WORD = 5,
    parameter int OSR      = 16,
    localparam int LEN_W   = $clog2(DATA_W - MIN_WORD + 1),
    localparam int IDX_W   = $clog2(DATA_W),
    localparam int CNT_W   = $clog2(2 * OSR + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic [1:0]        cfg_stop,
    input  logic              hold,
    output logic              tx_line,
    output logic              busy,
    output logic              cfg_err
);

    logic             accept;
    logic [CNT_W-1:0] stop_ticks;
    logic             stop_illegal;
    logic             par_bit;
    logic             par_en;
    logic [IDX_W-1:0] last_idx;

    assign in_ready = !busy && !hold;
    assign accept   = in_valid && in_ready;
    assign last_idx = IDX_W'(MIN_WORD - 1) + IDX_W'(cfg_len);

    sertx_stop_rule #(.OSR(OSR), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_stop (
        .len_code   (cfg_len),
        .stop_code  (cfg_stop),
        .stop_ticks (stop_ticks),
        .illegal    (stop_illegal)
    );

    sertx_parity #(.DATA_W(DATA_W), .MIN_WORD(MIN_WORD), .LEN_W(LEN_W)) u_par (
        .data     (in_data),
        .len_code (cfg_len),
        .mode     (cfg_par),
        .par_bit  (par_bit),
        .par_en   (par_en)
    );

    sertx_seq #(.DATA_W(DATA_W), .OSR(OSR), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .load         (accept),
        .load_data    (in_data),
        .load_last    (last_idx),
        .load_par_en  (par_en),
        .load_par_bit (par_bit),
        .load_stop    (stop_ticks),
        .tx_line      (tx_line),
        .busy         (busy)
    );

    // Set the error flag when a word is taken with a disallowed stop setting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
        end else if (accept && stop_illegal) begin
            cfg_err <= 1'b1;
        end
    end

endmodule

// File: rtl/sertx_frame_chk.sv
// Module sertx_frame_chk: checks properties of sertx_frame over time at its
// ports. It is bound to every instance of the top module.
module sertx_frame_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic in_valid,
    input logic in_ready,
    input logic hold,
    input logic tx_line,
    input logic busy,
    input logic cfg_err
);

    // R1: the line is at mark whenever no frame is in progress.
    assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_line);

    // R1: the first cycle of a frame shows the start bit.
    assert_start_space_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tx_line);

    // R6: without a tick nothing moves, and the frame does not end.
    assert_no_tick_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> ($stable(tx_line) && busy));

    // R7: an accepted word makes busy high in the next cycle.
    assert_accept_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> busy);

    // R7: no word is taken during a frame.
    assert_not_ready_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_ready);

    // R8: hold while idle keeps the block idle.
    assert_hold_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && hold) |=> !busy);

    // R5: the error flag is sticky.
    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R5: the error flag rises only after a word was accepted.
    assert_err_on_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> $past(in_valid && in_ready));

endmodule

bind sertx_frame sertx_frame_chk u_chk (.*);

// File: tb/sertx_frame_tb.sv
// Bench for sertx_frame: a behavioural model made of a queue of line
// segments is compared with the design on every clock.
module sertx_frame_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic [1:0] cfg_len = 2'd3;
    logic [1:0] cfg_par = 2'd0;
    logic [1:0] cfg_stop = 2'd0;
    logic       hold = 1'b0;
    logic       tx_line;
    logic       busy;
    logic       cfg_err;

    int checks = 0;
    int errors = 0;
    int tick_mode = 0;
    int tick_cnt = 0;
    logic [7:0] lfsr = 8'h5B;
    int cycles = 0;
    string scen = "reset";

    // Model state: line segments as level, remaining ticks and requirement.
    int    q_lvl[$];
    int    q_dur[$];
    string q_tag[$];
    logic  m_err = 1'b0;

    always #2 clk = ~clk;

    sertx_frame u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .cfg_len  (cfg_len),
        .cfg_par  (cfg_par),
        .cfg_stop (cfg_stop),
        .hold     (hold),
        .tx_line  (tx_line),
        .busy     (busy),
        .cfg_err  (cfg_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", tag, scen, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Tick generation: every cycle, every third cycle, or irregular.
    always @(posedge clk) begin
        #1;
        tick_cnt++;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (tick_mode)
            0:       tick = 1'b1;
            1:       tick = (tick_cnt % 3 == 0);
            default: tick = lfsr[0];
        endcase
    end

    // Reference model: advance the segments on ticks and take new words.
    always @(posedge clk) begin
        if (!rst_n) begin
            q_lvl.delete(); q_dur.delete(); q_tag.delete();
            m_err = 1'b0;
        end else begin
            bit take;
            take = in_valid && (q_lvl.size() == 0) && !hold;
            if (q_lvl.size() != 0 && tick) begin
                q_dur[0] = q_dur[0] - 1;
                if (q_dur[0] == 0) begin
                    void'(q_lvl.pop_front()); void'(q_dur.pop_front()); void'(q_tag.pop_front());
                end
            end
            if (take) begin
                int n;
                int p;
                int sdur;
                bit bad;
                n = 5 + int'(cfg_len);
                q_lvl.push_back(0); q_dur.push_back(16); q_tag.push_back("R1");
                p = 0;
                for (int i = 0; i < n; i++) begin
                    q_lvl.push_back(int'(in_data[i])); q_dur.push_back(16); q_tag.push_back("R2");
                    p = p ^ int'(in_data[i]);
                end
                if (cfg_par == 2'd1 || cfg_par == 2'd2) begin
                    if (cfg_par == 2'd2) p = 1 - p;
                    q_lvl.push_back(p); q_dur.push_back(16); q_tag.push_back("R3");
                end
                bad = 1'b0;
                sdur = 16;
                if (cfg_stop == 2'd1) begin
                    if (n == 5) sdur = 24; else bad = 1'b1;
                end else if (cfg_stop == 2'd2) begin
                    if (n > 5) sdur = 32; else bad = 1'b1;
                end else if (cfg_stop == 2'd3) begin
                    bad = 1'b1;
                end
                q_lvl.push_back(1); q_dur.push_back(sdur); q_tag.push_back(bad ? "R5" : "R4");
                if (bad) m_err = 1'b1;
            end
        end
    end

    // Compare every output with the model at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            int    exp_line;
            string ltag;
            exp_line = (q_lvl.size() == 0) ? 1 : q_lvl[0];
            ltag     = (q_lvl.size() == 0) ? "R1" : q_tag[0];
            check({ltag, "/R6 line"}, int'(tx_line), exp_line);
            check("R9 busy", int'(busy), (q_lvl.size() != 0) ? 1 : 0);
            check("R7 in_ready", int'(in_ready), (q_lvl.size() == 0 && !hold) ? 1 : 0);
            check("R5 cfg_err", int'(cfg_err), int'(m_err));
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cycles);
            finish_run();
        end
    end

    task automatic send(input logic [7:0] d, input logic [1:0] len,
                        input logic [1:0] par, input logic [1:0] stp);
        in_data  = d;
        cfg_len  = len;
        cfg_par  = par;
        cfg_stop = stp;
        in_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 reset line", int'(tx_line), 1);
        check("R1 reset busy", int'(busy), 0);
        check("R5 reset cfg_err", int'(cfg_err), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (3) @(posedge clk); #1;

        scen = "R2 8 bits";
        send(8'hA5, 2'd3, 2'd0, 2'd0); wait_idle();
        send(8'h3C, 2'd3, 2'd0, 2'd2); wait_idle();
        scen = "R3 even 7 bits";
        send(8'h6B, 2'd2, 2'd1, 2'd2); wait_idle();
        scen = "R4 odd 5 bits 1.5 stop";
        send(8'hF3, 2'd0, 2'd2, 2'd1); wait_idle();
        scen = "R3 code 3 no parity";
        send(8'h81, 2'd1, 2'd3, 2'd0); wait_idle();

        scen = "R6 slow tick";
        tick_mode = 1;
        send(8'h2E, 2'd1, 2'd2, 2'd2); wait_idle();
        send(8'h00, 2'd0, 2'd1, 2'd1); wait_idle();

        scen = "R9 back to back";
        tick_mode = 2;
        send(8'hC7, 2'd3, 2'd1, 2'd0);
        send(8'h19, 2'd2, 2'd2, 2'd2);
        send(8'hFF, 2'd0, 2'd2, 2'd0); wait_idle();
        tick_mode = 0;

        scen = "R8 hold idle";
        hold = 1'b1;
        in_data = 8'h55; cfg_len = 2'd3; in_valid = 1'b1;
        repeat (40) @(posedge clk);
        @(negedge clk);
        check("R8 held word not started", int'(busy), 0);
        @(posedge clk); #1;
        hold = 1'b0;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        scen = "R8 hold mid frame";
        repeat (30) @(posedge clk); #1;
        hold = 1'b1;
        repeat (60) @(posedge clk); #1;
        hold = 1'b0;
        wait_idle();

        scen = "R10 config change mid frame";
        send(8'h96, 2'd3, 2'd1, 2'd2);
        repeat (20) @(posedge clk); #1;
        in_data = 8'h0F; cfg_len = 2'd0; cfg_par = 2'd2; cfg_stop = 2'd1;
        wait_idle();
        check("R5 no error yet", int'(cfg_err), 0);

        scen = "R5 illegal 1.5 with 8 bits";
        send(8'h5A, 2'd3, 2'd0, 2'd1);
        @(negedge clk);
        check("R5 error set after acceptance", int'(cfg_err), 1);
        wait_idle();
        scen = "R5 illegal 2 with 5 bits";
        send(8'h13, 2'd0, 2'd1, 2'd2); wait_idle();
        scen = "R5 reserved stop code";
        send(8'hE8, 2'd2, 2'd0, 2'd3); wait_idle();
        check("R5 error sticky", int'(cfg_err), 1);

        scen = "R5 reset clears";
        rst_n = 1'b0;
        @(posedge clk); #1;
        @(negedge clk);
        check("R5 error cleared by reset", int'(cfg_err), 0);
        check("R1 line after reset", int'(tx_line), 1);
        finish_run();
    end

endmodule